// File: doc/BRIEF.md
# Instruction Cache Array Diagnostic Readout

This block holds the storage of a four-way set-associative instruction cache: a tag, a valid bit and a lock bit per way and set, and a sixteen-byte line of four 32-bit words per way and set. Software reads this storage indirectly. It first writes a command word into the command register. The command names the array (tag or data), the way, the set and, for data reads, the word. A later read of the result port returns either the selected data word or a packed tag/status word. The packed word also carries the set's replacement-order bits, which come in from outside the block.

Bits are numbered big-endian throughout: bit 0 is the most significant bit, so big-endian bit b is vector index 31-b. A separate fill port writes tags, valid bits, lock bits and line words, so the arrays can be loaded with known contents. Hit detection, refill, translation and replacement updates are not part of this block.

A two-state machine sequences bus reads. In `IDLE`, no reply is pending. A bus read strobe moves it to `REPLY` (transition *read accepted*), and the registered result is presented for one cycle. From `REPLY`, another strobe keeps it in `REPLY` (*back-to-back read*). Otherwise it returns to `IDLE` (*reply retired*).

Top module: `icache_diag_array`

## Requirements
- R1: After reset, the command register reads 0, `reg_rvalid` is 0, and every way/set reports valid=0 and lock=0 in a tag read.
- R2: A bus write with `reg_sel`=0 stores only command bits [14:2] (big-endian 17–29). All other bits read back as 0. A bus write with `reg_sel`=1 changes nothing.
- R3: A tag read (command vector bit [14]=0) returns the tag in [31:12], valid in [9] and lock in [8]. It returns `lru_bits` in [7:2], with `lru_bits[5]` at [7]. Bits [11:10] and [1:0] are 0.
- R4: A data read (command bit [14]=1) returns word `cmd[3:2]` (0–3) of the line at way `cmd[13:12]`, set `cmd[11:4]`.
- R5: For a tag read, the word field `cmd[3:2]` has no effect on the result.
- R6: Way `cmd[13:12]` and set `cmd[11:4]` select exactly one entry. Entries at different ways or sets do not alias.
- R7: A bus read strobe in cycle t yields `reg_rvalid`=1 with the result in cycle t+1. `reg_rvalid` is 0 in any cycle not preceded by a strobe.
- R8: A result-port read with no earlier command write is a tag read of way 0, set 0.
- R9: A lock write changes only the lock bit of the addressed way/set, leaving its valid bit intact. A tag write sets the tag and the valid bit.
- R10: `lru_set` always equals the set field of the command register, and the reply carries the `lru_bits` presented for that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe |
| reg_sel | input | 1 | Register select: 0 command register, 1 result port |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after strobe |
| fill_way | input | 2 | Way addressed by the fill port |
| fill_set | input | 8 | Set addressed by the fill port |
| fill_word | input | 2 | Word addressed by a data fill |
| tag_we | input | 1 | Write tag and valid bit |
| tag_wdata | input | 20 | Tag to store |
| valid_wdata | input | 1 | Valid bit to store with the tag |
| data_we | input | 1 | Write one line word |
| data_wdata | input | 32 | Line word to store |
| lock_we | input | 1 | Write lock bit |
| lock_wdata | input | 1 | Lock bit value |
| lru_set | output | 8 | Set whose replacement bits are requested |
| lru_bits | input | 6 | Replacement-order bits of `lru_set` |

## Verification
The assertions assume that the fill port is quiet in any cycle in which a result-port read is strobed, so that no read races a write to the entry it names. They also assume that `lru_bits` is a combinational function of `lru_set` and settles within the cycle. The bench drives fills and bus accesses from separate tasks that never overlap. It derives `lru_bits` from `lru_set` through a fixed XOR pattern, so every expected packed word can be computed from the set number alone.

// File: rtl/icd_pkg.sv
package icd_pkg;

    localparam int XLEN = 32;

    // command word field positions (vector index, big-endian bit = 31 - index)
    localparam int CMD_ARRAY_BIT = 14;
    localparam int CMD_WAY_LSB   = 12;
    localparam int CMD_SET_LSB   = 4;
    localparam int CMD_WORD_LSB  = 2;
    localparam logic [XLEN-1:0] CMD_KEEP_MASK = 32'h0000_7FFC;

    // packed tag reply positions
    localparam int RSP_TAG_LSB = 12;
    localparam int RSP_VALID   = 9;
    localparam int RSP_LOCK    = 8;
    localparam int RSP_LRU_LSB = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } diag_state_e;

    typedef enum logic [1:0] {
        RK_ADDR = 2'd0,
        RK_TAG  = 2'd1,
        RK_DATA = 2'd2
    } reply_kind_e;

endpackage

// File: rtl/icd_tag_store.sv
module icd_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [SET_W-1:0] wr_set,
    input  logic             tag_we,
    input  logic [TAG_W-1:0] tag_wdata,
    input  logic             valid_wdata,
    input  logic             lock_we,
    input  logic             lock_wdata,
    input  logic [WAY_W-1:0] rd_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_lock
);

    logic [TAG_W-1:0] way_tag   [WAYS];
    logic             way_valid [WAYS];
    logic             way_lock  [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  lock_q;
        logic             hit_wr;

        assign hit_wr = (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (tag_we && hit_wr) begin
                tag_mem[wr_set] <= tag_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
                lock_q  <= '0;
            end else begin
                if (tag_we && hit_wr) begin
                    valid_q[wr_set] <= valid_wdata;
                end
                if (lock_we && hit_wr) begin
                    lock_q[wr_set] <= lock_wdata;
                end
            end
        end

        assign way_tag[w]   = tag_mem[rd_set];
        assign way_valid[w] = valid_q[rd_set];
        assign way_lock[w]  = lock_q[rd_set];

        // R9: the lock bit written is the one seen afterwards
        a_r9_lock_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_we && hit_wr) |=> (lock_q[$past(wr_set)] == $past(lock_wdata)));

        // R9: a lock write leaves the valid bit alone
        a_r9_valid_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_we && hit_wr && !tag_we) |=> $stable(valid_q));
    end

    assign rd_tag   = way_tag[rd_way];
    assign rd_valid = way_valid[rd_way];
    assign rd_lock  = way_lock[rd_way];

endmodule

// File: rtl/icd_data_store.sv
module icd_data_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int WORDS = 4,
    parameter int XLEN  = 32,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS),
    localparam int DEPTH  = SETS * WORDS
) (
    input  logic              clk,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              data_we,
    input  logic [XLEN-1:0]   data_wdata,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WORD_W-1:0] rd_word,
    output logic [XLEN-1:0]   rd_data
);

    logic [XLEN-1:0] way_word [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [XLEN-1:0] line_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (data_we && (wr_way == WAY_W'(w))) begin
                line_mem[{wr_set, wr_word}] <= data_wdata;
            end
        end

        assign way_word[w] = line_mem[{rd_set, rd_word}];
    end

    assign rd_data = way_word[rd_way];

endmodule

// File: rtl/icd_diag_ctrl.sv
module icd_diag_ctrl
    import icd_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int WORDS = 4,
    parameter int TAG_W = 20,
    parameter int LRU_W = 6,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic              reg_rvalid,
    output logic [WAY_W-1:0]  sel_way,
    output logic [SET_W-1:0]  sel_set,
    output logic [WORD_W-1:0] sel_word,
    input  logic [TAG_W-1:0]  arr_tag,
    input  logic              arr_valid,
    input  logic              arr_lock,
    input  logic [XLEN-1:0]   arr_data,
    input  logic [LRU_W-1:0]  lru_in
);

    diag_state_e     state_q, state_d;
    reply_kind_e     kind_q;
    logic [XLEN-1:0] cmd_q;
    logic [XLEN-1:0] rdata_q;
    logic [XLEN-1:0] tag_word;
    logic            want_data;

    // command register: reserved bits never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (reg_wr && !reg_sel) begin
            cmd_q <= reg_wdata & CMD_KEEP_MASK;
        end
    end

    assign want_data = cmd_q[CMD_ARRAY_BIT];
    assign sel_way   = cmd_q[CMD_WAY_LSB  +: WAY_W];
    assign sel_set   = cmd_q[CMD_SET_LSB  +: SET_W];
    assign sel_word  = cmd_q[CMD_WORD_LSB +: WORD_W];

    always_comb begin
        tag_word = '0;
        tag_word[RSP_TAG_LSB +: TAG_W] = arr_tag;
        tag_word[RSP_VALID]            = arr_valid;
        tag_word[RSP_LOCK]             = arr_lock;
        tag_word[RSP_LRU_LSB +: LRU_W] = lru_in;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (reg_rd) state_d = ST_REPLY;
            ST_REPLY: state_d = reg_rd ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            kind_q  <= RK_ADDR;
        end else if (reg_rd) begin
            if (!reg_sel) begin
                rdata_q <= cmd_q;
                kind_q  <= RK_ADDR;
            end else if (want_data) begin
                rdata_q <= arr_data;
                kind_q  <= RK_DATA;
            end else begin
                rdata_q <= tag_word;
                kind_q  <= RK_TAG;
            end
        end
    end

    assign reg_rdata  = rdata_q;
    assign reg_rvalid = (state_q == ST_REPLY);

    a_r7_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    a_r7_no_stray_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    a_r3_tag_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rvalid && kind_q == RK_TAG) |->
            (reg_rdata[11:10] == 2'b00 && reg_rdata[1:0] == 2'b00));

    a_r2_cmd_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rvalid && kind_q == RK_ADDR) |-> ((reg_rdata & ~CMD_KEEP_MASK) == '0));

    a_r2_port_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> $stable(cmd_q));

endmodule

// File: rtl/icache_diag_array.sv
module icache_diag_array
    import icd_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int WORDS = 4,
    parameter int TAG_W = 20,
    parameter int LRU_W = 6,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SET_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              tag_we,
    input  logic [TAG_W-1:0]  tag_wdata,
    input  logic              valid_wdata,
    input  logic              data_we,
    input  logic [31:0]       data_wdata,
    input  logic              lock_we,
    input  logic              lock_wdata,
    output logic [SET_W-1:0]  lru_set,
    input  logic [LRU_W-1:0]  lru_bits
);

    logic [WAY_W-1:0]  sel_way;
    logic [SET_W-1:0]  sel_set;
    logic [WORD_W-1:0] sel_word;
    logic [TAG_W-1:0]  arr_tag;
    logic              arr_valid;
    logic              arr_lock;
    logic [XLEN-1:0]   arr_data;

    icd_diag_ctrl #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .LRU_W(LRU_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .sel_way(sel_way), .sel_set(sel_set), .sel_word(sel_word),
        .arr_tag(arr_tag), .arr_valid(arr_valid), .arr_lock(arr_lock),
        .arr_data(arr_data), .lru_in(lru_bits)
    );

    icd_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)
    ) tags_i (
        .clk(clk), .rst_n(rst_n),
        .wr_way(fill_way), .wr_set(fill_set),
        .tag_we(tag_we), .tag_wdata(tag_wdata), .valid_wdata(valid_wdata),
        .lock_we(lock_we), .lock_wdata(lock_wdata),
        .rd_way(sel_way), .rd_set(sel_set),
        .rd_tag(arr_tag), .rd_valid(arr_valid), .rd_lock(arr_lock)
    );

    icd_data_store #(
        .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .XLEN(XLEN)
    ) data_i (
        .clk(clk),
        .wr_way(fill_way), .wr_set(fill_set), .wr_word(fill_word),
        .data_we(data_we), .data_wdata(data_wdata),
        .rd_way(sel_way), .rd_set(sel_set), .rd_word(sel_word),
        .rd_data(arr_data)
    );

    assign lru_set = sel_set;

    // R10: the replacement query follows the command register's set field
    a_r10_lru_query_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> (lru_set == $past(reg_wdata[11:4])));

endmodule

// File: tb/icache_diag_array_tb.sv
module icache_diag_array_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [1:0]  fill_way;
    logic [7:0]  fill_set;
    logic [1:0]  fill_word;
    logic        tag_we, valid_wdata, data_we, lock_we, lock_wdata;
    logic [19:0] tag_wdata;
    logic [31:0] data_wdata;
    logic [7:0]  lru_set;
    logic [5:0]  lru_bits;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    icache_diag_array dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .fill_way(fill_way), .fill_set(fill_set), .fill_word(fill_word),
        .tag_we(tag_we), .tag_wdata(tag_wdata), .valid_wdata(valid_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .lock_we(lock_we), .lock_wdata(lock_wdata),
        .lru_set(lru_set), .lru_bits(lru_bits)
    );

    function automatic logic [5:0] lru_of(input logic [7:0] s);
        return s[5:0] ^ 6'h2A;
    endfunction

    assign lru_bits = lru_of(lru_set);

    function automatic logic [31:0] cmd(input logic d, input logic [1:0] w,
                                        input logic [7:0] s, input logic [1:0] wd);
        return (32'(d) << 14) | (32'(w) << 12) | (32'(s) << 4) | (32'(wd) << 2);
    endfunction

    function automatic logic [31:0] tagword(input logic [19:0] t, input logic v,
                                            input logic l, input logic [7:0] s);
        return {t, 2'b00, v, l, lru_of(s), 2'b00};
    endfunction

    function automatic logic [31:0] lineword(input logic [1:0] w, input logic [7:0] s,
                                             input logic [1:0] wd);
        return {8'hC3, 6'd0, w, s, 6'd0, wd} ^ 32'h0F0F_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cmd_write(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [31:0] d, output logic v);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        v = reg_rvalid;
    endtask

    task automatic fill_tag(input logic [1:0] w, input logic [7:0] s,
                            input logic [19:0] t, input logic v);
        @(negedge clk);
        tag_we = 1'b1; fill_way = w; fill_set = s; tag_wdata = t; valid_wdata = v;
        @(negedge clk);
        tag_we = 1'b0;
    endtask

    task automatic fill_lock(input logic [1:0] w, input logic [7:0] s, input logic l);
        @(negedge clk);
        lock_we = 1'b1; fill_way = w; fill_set = s; lock_wdata = l;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    task automatic fill_line(input logic [1:0] w, input logic [7:0] s);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            data_we = 1'b1; fill_way = w; fill_set = s; fill_word = 2'(k);
            data_wdata = lineword(w, s, 2'(k));
        end
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic v;
        check("R1 rvalid after reset", 32'(reg_rvalid), 32'd0);
        bus_read(1'b0, d, v);
        check("R1 command reg after reset", d, 32'd0);
        bus_read(1'b1, d, v);
        check("R8 default tag read status", d & 32'h0000_0FFF,
              tagword(20'd0, 1'b0, 1'b0, 8'd0) & 32'h0000_0FFF);
        cmd_write(cmd(1'b0, 2'd3, 8'd200, 2'd0));
        bus_read(1'b1, d, v);
        check("R1 valid/lock clear way3 set200", d & 32'h0000_0300, 32'd0);
    endtask

    task automatic t_cmd_mask;
        logic [31:0] d; logic v;
        cmd_write(32'hFFFF_FFFF);
        bus_read(1'b0, d, v);
        check("R2 reserved command bits dropped", d, 32'h0000_7FFC);
        check("R10 lru_set follows command", 32'(lru_set), 32'hFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_1234;
        @(negedge clk);
        reg_wr = 1'b0;
        bus_read(1'b0, d, v);
        check("R2 result-port write ignored", d, 32'h0000_7FFC);
        cmd_write(32'h0000_0000);
    endtask

    task automatic t_tag_reads;
        logic [31:0] d; logic v;
        fill_tag(2'd0, 8'd5,   20'hABCDE, 1'b1);
        fill_tag(2'd1, 8'd5,   20'h12345, 1'b1);
        fill_tag(2'd2, 8'd77,  20'hFEDCB, 1'b0);
        fill_tag(2'd3, 8'd255, 20'h0F0F0, 1'b1);
        cmd_write(cmd(1'b0, 2'd0, 8'd5, 2'd0));
        bus_read(1'b1, d, v);
        check("R3 tag read way0 set5", d, tagword(20'hABCDE, 1'b1, 1'b0, 8'd5));
        check("R7 rvalid with reply", 32'(v), 32'd1);
        cmd_write(cmd(1'b0, 2'd1, 8'd5, 2'd0));
        bus_read(1'b1, d, v);
        check("R6 tag read way1 set5", d, tagword(20'h12345, 1'b1, 1'b0, 8'd5));
        cmd_write(cmd(1'b0, 2'd2, 8'd77, 2'd0));
        bus_read(1'b1, d, v);
        check("R3 invalid entry way2 set77", d, tagword(20'hFEDCB, 1'b0, 1'b0, 8'd77));
        cmd_write(cmd(1'b0, 2'd3, 8'd255, 2'd0));
        bus_read(1'b1, d, v);
        check("R10 lru bits for set255", d, tagword(20'h0F0F0, 1'b1, 1'b0, 8'd255));
    endtask

    task automatic t_word_ignored;
        logic [31:0] d; logic v;
        cmd_write(cmd(1'b0, 2'd0, 8'd5, 2'd3));
        bus_read(1'b1, d, v);
        check("R5 word field ignored on tag read", d, tagword(20'hABCDE, 1'b1, 1'b0, 8'd5));
    endtask

    task automatic t_data_reads;
        logic [31:0] d; logic v;
        fill_line(2'd2, 8'd9);
        fill_line(2'd3, 8'd9);
        fill_line(2'd2, 8'd10);
        for (int k = 0; k < 4; k++) begin
            cmd_write(cmd(1'b1, 2'd2, 8'd9, 2'(k)));
            bus_read(1'b1, d, v);
            check("R4 data word way2 set9", d, lineword(2'd2, 8'd9, 2'(k)));
        end
        cmd_write(cmd(1'b1, 2'd3, 8'd9, 2'd1));
        bus_read(1'b1, d, v);
        check("R6 data word way3 set9", d, lineword(2'd3, 8'd9, 2'd1));
        cmd_write(cmd(1'b1, 2'd2, 8'd10, 2'd2));
        bus_read(1'b1, d, v);
        check("R6 data word way2 set10", d, lineword(2'd2, 8'd10, 2'd2));
    endtask

    task automatic t_lock;
        logic [31:0] d; logic v;
        fill_lock(2'd1, 8'd5, 1'b1);
        cmd_write(cmd(1'b0, 2'd1, 8'd5, 2'd0));
        bus_read(1'b1, d, v);
        check("R9 lock set, valid kept", d, tagword(20'h12345, 1'b1, 1'b1, 8'd5));
        cmd_write(cmd(1'b0, 2'd0, 8'd5, 2'd0));
        bus_read(1'b1, d, v);
        check("R9 neighbour way unlocked", d, tagword(20'hABCDE, 1'b1, 1'b0, 8'd5));
        fill_lock(2'd1, 8'd5, 1'b0);
        cmd_write(cmd(1'b0, 2'd1, 8'd5, 2'd0));
        bus_read(1'b1, d, v);
        check("R9 lock cleared", d, tagword(20'h12345, 1'b1, 1'b0, 8'd5));
    endtask

    task automatic t_timing;
        @(negedge clk);
        check("R7 idle before strobe", 32'(reg_rvalid), 32'd0);
        reg_rd = 1'b1; reg_sel = 1'b0;
        @(negedge clk);
        check("R7 first back-to-back reply", 32'(reg_rvalid), 32'd1);
        @(negedge clk);
        reg_rd = 1'b0;
        check("R7 second back-to-back reply", 32'(reg_rvalid), 32'd1);
        @(negedge clk);
        check("R7 reply retired", 32'(reg_rvalid), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        fill_way = '0; fill_set = '0; fill_word = '0;
        tag_we = 1'b0; tag_wdata = '0; valid_wdata = 1'b0;
        data_we = 1'b0; data_wdata = '0; lock_we = 1'b0; lock_wdata = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_mask();
        t_tag_reads();
        t_word_ignored();
        t_data_reads();
        t_lock();
        t_timing();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule